// File: doc/BRIEF.md
# Clock-crossing peripheral control register

This block is an 8-bit control register that lives on the bus clock and steers a peripheral clocked from an unrelated source. Software selects an operating mode (device or host), chooses whether the peripheral clock keeps running in standby, switches the peripheral on and off, and can request a software reset. The mode and standby settings are quasi-static and reach the peripheral through plain two-flop synchronizers. Enable and software reset are events that have to land in the peripheral domain reliably, so each travels over its own toggle request/acknowledge handshake.

A second, read-only status word shows one busy flag per handshake. A flag rises on the bus edge that accepts the write and drops only once the acknowledge has come back, so software can poll it to learn that the peripheral has seen the change. An external lock input blocks every write. A software reset returns the control fields to zero at once, disables the peripheral, produces one reset pulse on the peripheral clock, and reads back as 1 until the round trip completes.

Top module: `periph_ctrl_sync`

## Requirements
- R1: After reset the control word (address 0) and the status word (address 1) both read 0x00, and the peripheral enable, mode and standby outputs are 0.
- R2: Control word layout: bit 7 is host mode (1 = host, 0 = device), bit 2 is run-in-standby, bit 1 is enable, bit 0 is software reset; bits 6 to 3 always read 0.
- R3: An accepted write returns the written enable value on the next read and sets status bit 1 on the same edge. Status bit 1 clears only after the new value appears on per_enable.
- R4: While status bit 1 is set, the enable field of a write is ignored. The other fields of that write still apply.
- R5: Run-in-standby changes only when the enable bit reads 0 before the write. Otherwise the written value is dropped.
- R6: A write with bit 0 set discards every other field. The control word reads 0x01 and status bit 0 is set. On completion both clear together, mode, standby and enable are 0, per_enable is 0, and per_swrst has pulsed exactly once.
- R7: Writing 0 to bit 0 starts no reset: status bit 0 stays 0 and per_swrst does not pulse.
- R8: While wr_lock is 1, writes change no field and set no busy flag.
- R9: All writes are ignored while status bit 0 is set. A reset request is also ignored while status bit 1 is set.
- R10: The mode and standby bits reach per_host_mode and per_run_stdby in the peripheral clock domain.
- R11: Address 1 is read-only. Writing to it changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Active-low asynchronous reset, bus domain |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 1 | Word select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| wr_lock | input | 1 | Write-protect lock; 1 blocks all writes |
| rd_data | output | 8 | Read data of the word selected by addr |
| clk_per | input | 1 | Peripheral clock |
| rst_per_n | input | 1 | Active-low asynchronous reset, peripheral domain |
| per_enable | output | 1 | Enable as seen by the peripheral |
| per_swrst | output | 1 | One-cycle software reset pulse, peripheral clock |
| per_host_mode | output | 1 | Synchronized mode select |
| per_run_stdby | output | 1 | Synchronized run-in-standby |

## Verification
Two pairs of functions can meet in one access or cycle. The first pair is a write that changes the enable field while its crossing is still running: the bench issues a second write one idle cycle after the first and expects the enable field to keep its pending value while the mode and standby fields of the second write take effect. The second pair is a reset request against either crossing that is busy: the bench sends a reset request while enable is in flight, and sends a mode write while the reset is in flight. In both cases it expects the later write to vanish. The per_swrst pulse count and the final control value judge whether the reset ran exactly once.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int REG_W      = 8;
  localparam int SYNC_DEPTH = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int B_SWRST = 0;
  localparam int B_EN    = 1;
  localparam int B_STDBY = 2;
  localparam int B_MODE  = 7;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/ctl_xfer_hs.sv
module ctl_xfer_hs #(
  parameter int STAGES = 2
) (
  input  logic clk_a,
  input  logic rst_a_n,
  input  logic start,
  output logic busy,
  input  logic clk_b,
  input  logic rst_b_n,
  output logic strobe
);
  logic req_q, req_n, busy_q, busy_n, ack_s;
  logic req_s, req_d;

  // source side
  always_comb begin
    req_n  = req_q;
    busy_n = busy_q && (ack_s != req_q);
    if (start && !busy_q) begin
      req_n  = ~req_q;
      busy_n = 1'b1;
    end
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      req_q  <= req_n;
      busy_q <= busy_n;
    end
  end

  ctl_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(clk_a), .rst_n(rst_a_n), .d(req_d), .q(ack_s)
  );

  // destination side
  ctl_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(clk_b), .rst_n(rst_b_n), .d(req_q), .q(req_s)
  );

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) req_d <= 1'b0;
    else          req_d <= req_s;
  end

  assign strobe = req_s ^ req_d;
  assign busy   = busy_q;

  // R3: busy only rises from an accepted start
  a_r3_busy_from_start: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/ctl_bus_regs.sv
module ctl_bus_regs
  import ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_lock,
  input  logic             en_busy,
  input  logic             sw_busy,
  output logic [REG_W-1:0] rd_data,
  output logic             en_q,
  output logic             mode_q,
  output logic             stdby_q,
  output logic             en_start,
  output logic             sw_start
);
  logic accept, plain_wr;
  logic en_n, mode_n, stdby_n;
  logic unused_wbits;

  assign unused_wbits = ^wr_data[B_MODE-1:B_STDBY+1];

  assign accept   = wr_en && (addr == ADDR_CTRL) && !wr_lock && !sw_busy;
  assign sw_start = accept && wr_data[B_SWRST] && !en_busy;
  assign plain_wr = accept && !wr_data[B_SWRST];
  assign en_start = plain_wr && !en_busy;

  always_comb begin
    en_n    = en_q;
    mode_n  = mode_q;
    stdby_n = stdby_q;
    if (sw_start) begin
      en_n    = 1'b0;
      mode_n  = 1'b0;
      stdby_n = 1'b0;
    end else if (plain_wr) begin
      mode_n = wr_data[B_MODE];
      if (!en_q)    stdby_n = wr_data[B_STDBY];
      if (en_start) en_n    = wr_data[B_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      stdby_q <= 1'b0;
    end else begin
      en_q    <= en_n;
      mode_q  <= mode_n;
      stdby_q <= stdby_n;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_CTRL) begin
      rd_data[B_MODE]  = mode_q;
      rd_data[B_STDBY] = stdby_q;
      rd_data[B_EN]    = en_q;
      rd_data[B_SWRST] = sw_busy;
    end else begin
      rd_data[B_EN]    = en_busy;
      rd_data[B_SWRST] = sw_busy;
    end
  end

  // R4: enable is frozen while its crossing runs
  a_r4_en_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_busy |=> $stable(en_q));
  // R5: standby is locked while enabled, unless a reset clears it
  a_r5_stdby_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !sw_start) |=> $stable(stdby_q));
  // R8: a locked write touches nothing and starts no crossing
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lock && !en_busy && !sw_busy) |=> ($stable({mode_q, stdby_q, en_q}) && !en_busy && !sw_busy));
  // R6: a reset request reads back as 0x01 on the next cycle
  a_r6_swrst_readback: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> (sw_busy && !en_q && !mode_q && !stdby_q));
endmodule

// File: rtl/ctl_per_side.sv
module ctl_per_side (
  input  logic clk,
  input  logic rst_n,
  input  logic en_strobe,
  input  logic sw_strobe,
  input  logic en_src,
  output logic per_enable,
  output logic per_swrst
);
  logic en_q, en_n, rst_q;

  // en_src is held still by the source side while its crossing is busy
  always_comb begin
    en_n = en_q;
    if (sw_strobe)      en_n = 1'b0;
    else if (en_strobe) en_n = en_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      rst_q <= sw_strobe;
    end
  end

  assign per_enable = en_q;
  assign per_swrst  = rst_q;

  // R6: the reset pulse always leaves the peripheral disabled
  a_r6_pulse_disables: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !en_q);
endmodule

// File: rtl/periph_ctrl_sync.sv
module periph_ctrl_sync
  import ctl_pkg::*;
(
  input  logic             clk_bus,
  input  logic             rst_bus_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_lock,
  output logic [REG_W-1:0] rd_data,
  input  logic             clk_per,
  input  logic             rst_per_n,
  output logic             per_enable,
  output logic             per_swrst,
  output logic             per_host_mode,
  output logic             per_run_stdby
);
  logic en_q, mode_q, stdby_q, en_start, sw_start;
  logic en_busy, sw_busy, en_strobe, sw_strobe;
  logic [1:0] ms_sync;

  ctl_bus_regs u_regs (
    .clk(clk_bus), .rst_n(rst_bus_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .wr_lock(wr_lock), .en_busy(en_busy), .sw_busy(sw_busy),
    .rd_data(rd_data), .en_q(en_q), .mode_q(mode_q), .stdby_q(stdby_q),
    .en_start(en_start), .sw_start(sw_start)
  );

  ctl_xfer_hs #(.STAGES(SYNC_DEPTH)) u_en_hs (
    .clk_a(clk_bus), .rst_a_n(rst_bus_n), .start(en_start), .busy(en_busy),
    .clk_b(clk_per), .rst_b_n(rst_per_n), .strobe(en_strobe)
  );

  ctl_xfer_hs #(.STAGES(SYNC_DEPTH)) u_sw_hs (
    .clk_a(clk_bus), .rst_a_n(rst_bus_n), .start(sw_start), .busy(sw_busy),
    .clk_b(clk_per), .rst_b_n(rst_per_n), .strobe(sw_strobe)
  );

  ctl_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_ms_sync (
    .clk(clk_per), .rst_n(rst_per_n), .d({mode_q, stdby_q}), .q(ms_sync)
  );

  ctl_per_side u_per (
    .clk(clk_per), .rst_n(rst_per_n), .en_strobe(en_strobe),
    .sw_strobe(sw_strobe), .en_src(en_q),
    .per_enable(per_enable), .per_swrst(per_swrst)
  );

  assign per_host_mode = ms_sync[1];
  assign per_run_stdby = ms_sync[0];

  // R9: a reset request never starts while the enable crossing runs
  a_r9_no_reset_over_enable: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (en_busy && !sw_busy) |=> !sw_busy);
endmodule

// File: tb/periph_ctrl_sync_tb.sv
module periph_ctrl_sync_tb;
  logic clk_bus = 1'b0, clk_per = 1'b0;
  logic rst_bus_n, rst_per_n;
  logic wr_en, addr, wr_lock;
  logic [7:0] wr_data, rd_data;
  logic per_enable, per_swrst, per_host_mode, per_run_stdby;

  int n_chk = 0, n_bad = 0, pulses = 0;
  bit done = 0;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #5 clk_bus = ~clk_bus;
  always #7 clk_per = ~clk_per;

  periph_ctrl_sync u_dut (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .wr_lock(wr_lock), .rd_data(rd_data),
    .clk_per(clk_per), .rst_per_n(rst_per_n), .per_enable(per_enable),
    .per_swrst(per_swrst), .per_host_mode(per_host_mode), .per_run_stdby(per_run_stdby)
  );

  always @(posedge clk_per) if (rst_per_n && per_swrst) pulses <= pulses + 1;

  // monitor: pop one expectation per falling bus edge
  always @(negedge clk_bus) begin
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = rd_data;
        1:       act = {5'b0, per_host_mode, per_run_stdby, per_enable};
        default: act = 8'(pulses);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk_bus); #1;
  endtask

  task automatic chk_reg(input logic a, input logic [7:0] exp, input string tag);
    addr = a;
    push(0, exp, tag);
  endtask

  task automatic do_write(input logic a, input logic [7:0] d, input logic lk);
    @(posedge clk_bus); #1;
    wr_en = 1'b1; addr = a; wr_data = d; wr_lock = lk;
    @(posedge clk_bus); #1;
    wr_en = 1'b0; wr_lock = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    bit ok = 0;
    addr = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk_bus); #1;
      if (rd_data === 8'h00) begin ok = 1; break; end
    end
    if (!ok) begin
      n_chk++; n_bad++;
      $display("FAIL %s: actual %h expected 00 (busy never cleared)", tag, rd_data);
    end
    repeat (10) @(posedge clk_bus);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_bus_n = 1'b0; rst_per_n = 1'b0;
    wr_en = 1'b0; addr = 1'b0; wr_data = 8'h00; wr_lock = 1'b0;
    repeat (4) @(posedge clk_bus);
    #1 rst_bus_n = 1'b1; rst_per_n = 1'b1;
    repeat (3) @(posedge clk_bus);
    #1;
    // R1 reset state
    chk_reg(1'b0, 8'h00, "R1 ctrl after reset");
    chk_reg(1'b1, 8'h00, "R1 status after reset");
    push(1, 8'h00, "R1 peripheral outputs after reset");

    // R2 layout, R3 readback and busy, R7 no reset on bit0=0
    do_write(1'b0, 8'hFE, 1'b0);
    chk_reg(1'b0, 8'h86, "R2 unimplemented bits read 0");
    chk_reg(1'b1, 8'h02, "R3 enable busy set");
    wait_idle("R3 enable crossing");
    push(1, 8'h07, "R3 R10 enable mode standby at peripheral");
    push(2, 8'd0, "R7 no reset pulse");

    // R5 standby protected while enabled
    do_write(1'b0, 8'h82, 1'b0);
    chk_reg(1'b0, 8'h86, "R5 standby kept while enabled");
    wait_idle("R5 crossing");

    // R4 enable field ignored while busy, other fields applied
    do_write(1'b0, 8'h00, 1'b0);
    chk_reg(1'b0, 8'h04, "R4 first write");
    do_write(1'b0, 8'h06, 1'b0);
    chk_reg(1'b0, 8'h04, "R4 enable ignored while busy");
    wait_idle("R4 crossing");
    push(1, 8'h02, "R4 R10 peripheral disabled standby kept");

    // R8 lock
    do_write(1'b0, 8'h83, 1'b1);
    chk_reg(1'b0, 8'h04, "R8 locked write ignored");
    chk_reg(1'b1, 8'h00, "R8 no busy under lock");
    repeat (20) @(posedge clk_bus);
    #1;
    push(2, 8'd0, "R8 no reset pulse under lock");

    // R11 status read-only
    do_write(1'b1, 8'hFF, 1'b0);
    chk_reg(1'b1, 8'h00, "R11 status unchanged");
    chk_reg(1'b0, 8'h04, "R11 ctrl unchanged");

    // R9 reset request during enable crossing is ignored
    do_write(1'b0, 8'h02, 1'b0);
    chk_reg(1'b0, 8'h02, "R9 enable write");
    do_write(1'b0, 8'h01, 1'b0);
    chk_reg(1'b0, 8'h02, "R9 reset ignored while enable busy");
    wait_idle("R9 crossing");
    push(2, 8'd0, "R9 no reset pulse");
    push(1, 8'h01, "R9 peripheral enabled");

    // R6 reset discards fields; R9 writes ignored during reset
    do_write(1'b0, 8'h87, 1'b0);
    chk_reg(1'b0, 8'h01, "R6 reset readback");
    chk_reg(1'b1, 8'h01, "R6 reset busy");
    do_write(1'b0, 8'h80, 1'b0);
    chk_reg(1'b0, 8'h01, "R9 write ignored during reset");
    wait_idle("R6 reset crossing");
    chk_reg(1'b0, 8'h00, "R6 ctrl after reset done");
    push(1, 8'h00, "R6 peripheral disabled");
    push(2, 8'd1, "R6 one reset pulse");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule